// File: doc/BRIEF.md
# Register Rename Manager with Split Architectural and Speculative Files

This block keeps the committed register state of an out-of-order core apart from results that exist but have not yet been retired. A bank of architectural registers holds committed values. A separate pool of rename entries holds results that are in flight. Each architectural register carries a busy flag and a mapping to the rename entry that will produce its next value. Each rename entry carries a busy flag, a valid flag, a data word and the index of the architectural register it belongs to.

At dispatch, two source registers are resolved in the same cycle. Each one yields either a usable value or the tag of the rename entry the consumer must wait for. The value comes from the architectural bank, from a finished rename entry, or from a result being written in that same cycle. An instruction that writes a register also claims a free rename entry and receives its tag. When an execution unit finishes, it writes its result into the entry named by its tag. When the instruction completes in program order, the entry's value is copied into the architectural bank and the entry is released.

The dispatch port uses a valid/ready handshake. A dispatch is accepted in a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` drops only when the instruction needs a destination and no rename entry is free. In that case `disp_stall` rises, the dispatch must be held, and nothing is changed. A dispatch without a destination is never held back. The finish and completion ports carry no back-pressure and are always accepted. A completion must come at least one cycle after the finish of the same tag.

Top module: `rnm_core`

## Requirements
- R1: After reset every architectural register reads as ready with value 0, `disp_ready` is 1 and `disp_stall` is 0.
- R2: A source whose architectural register is not busy returns `srcN_rdy`=1 and the architectural value.
- R3: A source whose register is busy, and whose mapped rename entry holds a finished result, returns `srcN_rdy`=1 and that entry's value.
- R4: A source whose register is busy, and whose mapped entry is not finished, returns `srcN_rdy`=0 and the entry's index on `srcN_tag`.
- R5: An accepted dispatch with `disp_dst_en`=1 claims the lowest-index free rename entry, shown on `disp_dst_tag`. That entry starts unfinished and becomes the mapping of the destination register.
- R6: A dispatch with `disp_dst_en`=0 claims no entry and changes no mapping.
- R7: With all entries busy, a dispatch with a destination sees `disp_stall`=1 and `disp_ready`=0 and changes nothing. A dispatch without a destination still sees `disp_ready`=1.
- R8: A finish write stores data into the entry named by `fin_tag` and marks it finished. A finish aimed at a free entry is ignored.
- R9: A completion copies the entry's value into its architectural register and frees the entry. The register then reads as ready with that value, unless a newer mapping exists.
- R10: A completion clears the register's busy flag only when the register still maps to the completing entry. A stale completion leaves a newer mapping waiting.
- R11: A source read in the same cycle as a finish write to its mapped tag returns `srcN_rdy`=1 and the data being written.
- R12: When a completion and a new allocation hit the same architectural register in one cycle, the new mapping wins and the register stays busy.
- R13: Sources of a dispatch are resolved against the mapping before that same dispatch's allocation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_stall | output | 1 | Destination requested but no entry is free |
| disp_src0_idx | input | 3 | First source register index |
| disp_src1_idx | input | 3 | Second source register index |
| disp_dst_en | input | 1 | Instruction writes a register |
| disp_dst_idx | input | 3 | Destination register index |
| disp_dst_tag | output | 3 | Rename entry claimed by this dispatch |
| src0_rdy | output | 1 | First source value is available |
| src0_data | output | 32 | First source value (0 when not ready) |
| src0_tag | output | 3 | Entry to wait on for the first source |
| src1_rdy | output | 1 | Second source value is available |
| src1_data | output | 32 | Second source value (0 when not ready) |
| src1_tag | output | 3 | Entry to wait on for the second source |
| fin_valid | input | 1 | Execution result present |
| fin_tag | input | 3 | Entry receiving the result |
| fin_data | input | 32 | Result value |
| cmp_valid | input | 1 | In-order completion of an entry |
| cmp_tag | input | 3 | Entry being completed |

## Verification
Three pairs of functions can land in one cycle. A source read can meet a finish write to its own tag. A completion can meet a new allocation to the same register. A completion can also meet an allocation while the completing entry still counts as busy. Directed tasks drive both ports in a single cycle. The bench then judges the result at the outputs: a source read must show the forwarded data at once; a later read of the register must show the newer tag still waiting; and the claimed tag must skip the entry still being released.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  typedef enum logic [1:0] {
    SRC_ARCH = 2'd0,
    SRC_SPEC = 2'd1,
    SRC_FWD  = 2'd2,
    SRC_WAIT = 2'd3
  } src_kind_e;
endpackage

// File: rtl/rnm_free_pick.sv
module rnm_free_pick #(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic [N-1:0]  busy,
  output logic          any_free,
  output logic [TW-1:0] pick
);
  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        pick     = TW'(i);
      end
    end
  end
endmodule

// File: rtl/rnm_arch_bank.sv
module rnm_arch_bank #(
  parameter int NR = 8,
  parameter int AW = 3,
  parameter int TW = 3,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic [AW-1:0]          alloc_idx,
  input  logic [TW-1:0]          alloc_tag,
  input  logic                   cmp_en,
  input  logic [AW-1:0]          cmp_idx,
  input  logic [TW-1:0]          cmp_tag,
  input  logic [DW-1:0]          cmp_data,
  output logic [NR-1:0]          busy,
  output logic [NR-1:0][TW-1:0]  map,
  output logic [NR-1:0][DW-1:0]  data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      map  <= '0;
      data <= '0;
    end else begin
      if (cmp_en) begin
        data[cmp_idx] <= cmp_data;
        if (map[cmp_idx] == cmp_tag) busy[cmp_idx] <= 1'b0;
      end
      // allocation is applied last so a fresh mapping survives a completion
      if (alloc_en) begin
        busy[alloc_idx] <= 1'b1;
        map[alloc_idx]  <= alloc_tag;
      end
    end
  end
endmodule

// File: rtl/rnm_spec_bank.sv
module rnm_spec_bank #(
  parameter int NE = 8,
  parameter int AW = 3,
  parameter int TW = 3,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic [TW-1:0]          alloc_tag,
  input  logic [AW-1:0]          alloc_dst,
  input  logic                   fin_en,
  input  logic [TW-1:0]          fin_tag,
  input  logic [DW-1:0]          fin_data,
  input  logic                   cmp_en,
  input  logic [TW-1:0]          cmp_tag,
  output logic [NE-1:0]          busy,
  output logic [NE-1:0]          done,
  output logic [NE-1:0][DW-1:0]  data,
  output logic [NE-1:0][AW-1:0]  dest
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      done <= '0;
      data <= '0;
      dest <= '0;
    end else begin
      if (cmp_en) begin
        busy[cmp_tag] <= 1'b0;
        done[cmp_tag] <= 1'b0;
      end
      if (fin_en) begin
        data[fin_tag] <= fin_data;
        done[fin_tag] <= 1'b1;
      end
      if (alloc_en) begin
        busy[alloc_tag] <= 1'b1;
        done[alloc_tag] <= 1'b0;
        dest[alloc_tag] <= alloc_dst;
      end
    end
  end
endmodule

// File: rtl/rnm_src_read.sv
module rnm_src_read
  import rnm_pkg::*;
#(
  parameter int NR = 8,
  parameter int NE = 8,
  parameter int AW = 3,
  parameter int TW = 3,
  parameter int DW = 32
) (
  input  logic [AW-1:0]          idx,
  input  logic [NR-1:0]          arch_busy,
  input  logic [NR-1:0][TW-1:0]  arch_map,
  input  logic [NR-1:0][DW-1:0]  arch_data,
  input  logic [NE-1:0]          spec_done,
  input  logic [NE-1:0][DW-1:0]  spec_data,
  input  logic                   fin_en,
  input  logic [TW-1:0]          fin_tag,
  input  logic [DW-1:0]          fin_data,
  output logic                   rdy,
  output logic [DW-1:0]          data,
  output logic [TW-1:0]          tag
);
  src_kind_e kind;

  assign tag = arch_map[idx];

  always_comb begin
    if (!arch_busy[idx])                kind = SRC_ARCH;
    else if (fin_en && fin_tag == tag)  kind = SRC_FWD;
    else if (spec_done[tag])            kind = SRC_SPEC;
    else                                kind = SRC_WAIT;
  end

  always_comb begin
    unique case (kind)
      SRC_ARCH: data = arch_data[idx];
      SRC_FWD:  data = fin_data;
      SRC_SPEC: data = spec_data[tag];
      default:  data = '0;
    endcase
  end

  assign rdy = (kind != SRC_WAIT);
endmodule

// File: rtl/rnm_core.sv
module rnm_core #(
  parameter int ARCH_REGS = 8,
  parameter int SPEC_ENTS = 8,
  parameter int DW        = 32,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(SPEC_ENTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  output logic          disp_ready,
  output logic          disp_stall,
  input  logic [AW-1:0] disp_src0_idx,
  input  logic [AW-1:0] disp_src1_idx,
  input  logic          disp_dst_en,
  input  logic [AW-1:0] disp_dst_idx,
  output logic [TW-1:0] disp_dst_tag,
  output logic          src0_rdy,
  output logic [DW-1:0] src0_data,
  output logic [TW-1:0] src0_tag,
  output logic          src1_rdy,
  output logic [DW-1:0] src1_data,
  output logic [TW-1:0] src1_tag,
  input  logic          fin_valid,
  input  logic [TW-1:0] fin_tag,
  input  logic [DW-1:0] fin_data,
  input  logic          cmp_valid,
  input  logic [TW-1:0] cmp_tag
);
  localparam int NSRC = 2;

  logic [ARCH_REGS-1:0]          arch_busy;
  logic [ARCH_REGS-1:0][TW-1:0]  arch_map;
  logic [ARCH_REGS-1:0][DW-1:0]  arch_data;
  logic [SPEC_ENTS-1:0]          spec_busy;
  logic [SPEC_ENTS-1:0]          spec_done;
  logic [SPEC_ENTS-1:0][DW-1:0]  spec_data;
  logic [SPEC_ENTS-1:0][AW-1:0]  spec_dest;

  logic          any_free;
  logic [TW-1:0] free_tag;
  logic          alloc_en;
  logic          fin_en;
  logic          cmp_en;

  logic [NSRC-1:0][AW-1:0] s_idx;
  logic [NSRC-1:0]         s_rdy;
  logic [NSRC-1:0][DW-1:0] s_data;
  logic [NSRC-1:0][TW-1:0] s_tag;

  rnm_free_pick #(.N(SPEC_ENTS), .TW(TW)) u_pick (
    .busy     (spec_busy),
    .any_free (any_free),
    .pick     (free_tag)
  );

  assign disp_ready   = !disp_dst_en || any_free;
  assign disp_stall   = disp_valid && disp_dst_en && !any_free;
  assign disp_dst_tag = free_tag;
  assign alloc_en     = disp_valid && disp_dst_en && any_free;
  assign fin_en       = fin_valid && spec_busy[fin_tag];
  assign cmp_en       = cmp_valid && spec_busy[cmp_tag];

  rnm_arch_bank #(.NR(ARCH_REGS), .AW(AW), .TW(TW), .DW(DW)) u_arch (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_idx (disp_dst_idx),
    .alloc_tag (free_tag),
    .cmp_en    (cmp_en),
    .cmp_idx   (spec_dest[cmp_tag]),
    .cmp_tag   (cmp_tag),
    .cmp_data  (spec_data[cmp_tag]),
    .busy      (arch_busy),
    .map       (arch_map),
    .data      (arch_data)
  );

  rnm_spec_bank #(.NE(SPEC_ENTS), .AW(AW), .TW(TW), .DW(DW)) u_spec (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_tag (free_tag),
    .alloc_dst (disp_dst_idx),
    .fin_en    (fin_en),
    .fin_tag   (fin_tag),
    .fin_data  (fin_data),
    .cmp_en    (cmp_en),
    .cmp_tag   (cmp_tag),
    .busy      (spec_busy),
    .done      (spec_done),
    .data      (spec_data),
    .dest      (spec_dest)
  );

  assign s_idx[0] = disp_src0_idx;
  assign s_idx[1] = disp_src1_idx;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rnm_src_read #(
      .NR(ARCH_REGS), .NE(SPEC_ENTS), .AW(AW), .TW(TW), .DW(DW)
    ) u_rd (
      .idx       (s_idx[g]),
      .arch_busy (arch_busy),
      .arch_map  (arch_map),
      .arch_data (arch_data),
      .spec_done (spec_done),
      .spec_data (spec_data),
      .fin_en    (fin_en),
      .fin_tag   (fin_tag),
      .fin_data  (fin_data),
      .rdy       (s_rdy[g]),
      .data      (s_data[g]),
      .tag       (s_tag[g])
    );
  end

  assign src0_rdy  = s_rdy[0];
  assign src0_data = s_data[0];
  assign src0_tag  = s_tag[0];
  assign src1_rdy  = s_rdy[1];
  assign src1_data = s_data[1];
  assign src1_tag  = s_tag[1];
endmodule

// File: rtl/rnm_core_chk.sv
module rnm_core_chk #(
  parameter int NE = 8,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic          disp_stall,
  input logic          disp_dst_en,
  input logic [TW-1:0] disp_dst_tag,
  input logic          src0_rdy,
  input logic [TW-1:0] src0_tag,
  input logic          fin_valid,
  input logic [TW-1:0] fin_tag,
  input logic          cmp_valid,
  input logic [TW-1:0] cmp_tag,
  input logic [NE-1:0] spec_busy,
  input logic [NE-1:0] spec_done
);
  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> !disp_ready);

  p_refuse_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready |-> (disp_dst_en && (&spec_busy)));

  p_alloc_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_dst_en) |=>
      (spec_busy[$past(disp_dst_tag)] && !spec_done[$past(disp_dst_tag)]));

  p_fin_marks_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && spec_busy[fin_tag]) |=> spec_done[$past(fin_tag)]);

  p_cmp_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && spec_busy[cmp_tag]) |=> !spec_busy[$past(cmp_tag)]);

  p_wait_on_live_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !src0_rdy) |-> (spec_busy[src0_tag] && !spec_done[src0_tag]));
endmodule

bind rnm_core rnm_core_chk #(.NE(SPEC_ENTS), .TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .disp_valid   (disp_valid),
  .disp_ready   (disp_ready),
  .disp_stall   (disp_stall),
  .disp_dst_en  (disp_dst_en),
  .disp_dst_tag (disp_dst_tag),
  .src0_rdy     (src0_rdy),
  .src0_tag     (src0_tag),
  .fin_valid    (fin_valid),
  .fin_tag      (fin_tag),
  .cmp_valid    (cmp_valid),
  .cmp_tag      (cmp_tag),
  .spec_busy    (spec_busy),
  .spec_done    (spec_done)
);

// File: tb/rnm_core_test.sv
module rnm_core_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic        disp_ready, disp_stall;
  logic [2:0]  disp_src0_idx = '0, disp_src1_idx = '0;
  logic        disp_dst_en = 1'b0;
  logic [2:0]  disp_dst_idx = '0;
  logic [2:0]  disp_dst_tag;
  logic        src0_rdy, src1_rdy;
  logic [31:0] src0_data, src1_data;
  logic [2:0]  src0_tag, src1_tag;
  logic        fin_valid = 1'b0;
  logic [2:0]  fin_tag = '0;
  logic [31:0] fin_data = '0;
  logic        cmp_valid = 1'b0;
  logic [2:0]  cmp_tag = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rnm_core uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_stall(disp_stall),
    .disp_src0_idx(disp_src0_idx), .disp_src1_idx(disp_src1_idx),
    .disp_dst_en(disp_dst_en), .disp_dst_idx(disp_dst_idx), .disp_dst_tag(disp_dst_tag),
    .src0_rdy(src0_rdy), .src0_data(src0_data), .src0_tag(src0_tag),
    .src1_rdy(src1_rdy), .src1_data(src1_data), .src1_tag(src1_tag),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_data(fin_data),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dsp(input logic [2:0] s0, input logic [2:0] s1,
                     input logic den, input logic [2:0] d);
    disp_valid = 1'b1; disp_src0_idx = s0; disp_src1_idx = s1;
    disp_dst_en = den; disp_dst_idx = d;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    disp_valid = 1'b0; disp_dst_en = 1'b0;
    fin_valid = 1'b0; cmp_valid = 1'b0;
  endtask

  task automatic fin(input logic [2:0] t, input logic [31:0] v);
    fin_valid = 1'b1; fin_tag = t; fin_data = v;
    tick();
  endtask

  task automatic cmp(input logic [2:0] t);
    cmp_valid = 1'b1; cmp_tag = t;
    tick();
  endtask

  task automatic t_reset();
    dsp(3'd3, 3'd7, 1'b0, 3'd0);
    chk("R1 src0_rdy", 32'(src0_rdy), 32'd1);
    chk("R1 src0_data", src0_data, 32'd0);
    chk("R1 src1_data", src1_data, 32'd0);
    chk("R1 disp_ready", 32'(disp_ready), 32'd1);
    chk("R1 disp_stall", 32'(disp_stall), 32'd0);
    tick();
  endtask

  task automatic t_alloc();
    dsp(3'd2, 3'd2, 1'b1, 3'd2);
    chk("R13 src0 before own alloc", 32'(src0_rdy), 32'd1);
    chk("R13 src1 before own alloc", 32'(src1_rdy), 32'd1);
    chk("R5 lowest free tag", 32'(disp_dst_tag), 32'd0);
    tick();
    dsp(3'd2, 3'd0, 1'b1, 3'd5);
    chk("R4 waiting rdy", 32'(src0_rdy), 32'd0);
    chk("R4 waiting tag", 32'(src0_tag), 32'd0);
    chk("R2 arch read rdy", 32'(src1_rdy), 32'd1);
    chk("R5 next tag", 32'(disp_dst_tag), 32'd1);
    tick();
  endtask

  task automatic t_finish();
    fin(3'd0, 32'h11);
    dsp(3'd2, 3'd5, 1'b0, 3'd0);
    chk("R3 finished rdy", 32'(src0_rdy), 32'd1);
    chk("R3 finished data", src0_data, 32'h11);
    chk("R4 unfinished tag", 32'(src1_tag), 32'd1);
    tick();
  endtask

  task automatic t_forward();
    fin_valid = 1'b1; fin_tag = 3'd1; fin_data = 32'h22;
    dsp(3'd5, 3'd5, 1'b0, 3'd0);
    chk("R11 forward rdy", 32'(src0_rdy), 32'd1);
    chk("R11 forward data", src0_data, 32'h22);
    tick();
    dsp(3'd5, 3'd5, 1'b0, 3'd0);
    chk("R8 stored result", src1_data, 32'h22);
    tick();
  endtask

  task automatic t_complete();
    cmp(3'd0);
    cmp(3'd1);
    dsp(3'd2, 3'd5, 1'b0, 3'd0);
    chk("R9 r2 committed", src0_data, 32'h11);
    chk("R9 r5 committed", src1_data, 32'h22);
    chk("R9 ready", 32'(src0_rdy & src1_rdy), 32'd1);
    tick();
  endtask

  task automatic t_nodst();
    for (int i = 0; i < 3; i++) begin
      dsp(3'd1, 3'd1, 1'b0, 3'd1);
      tick();
    end
    dsp(3'd1, 3'd1, 1'b0, 3'd1);
    chk("R6 mapping unchanged", 32'(src0_rdy), 32'd1);
    tick();
    dsp(3'd0, 3'd0, 1'b1, 3'd1);
    chk("R6 no entry consumed", 32'(disp_dst_tag), 32'd0);
    tick();
    fin(3'd0, 32'h33);
    cmp(3'd0);
    dsp(3'd1, 3'd1, 1'b0, 3'd0);
    chk("R9 r1 committed", src0_data, 32'h33);
    tick();
  endtask

  task automatic t_stale();
    dsp(3'd0, 3'd0, 1'b1, 3'd3);
    chk("R5 first r3 tag", 32'(disp_dst_tag), 32'd0);
    tick();
    dsp(3'd0, 3'd0, 1'b1, 3'd3);
    chk("R5 second r3 tag", 32'(disp_dst_tag), 32'd1);
    tick();
    fin(3'd0, 32'h44);
    cmp(3'd0);
    dsp(3'd3, 3'd3, 1'b0, 3'd0);
    chk("R10 stale completion rdy", 32'(src0_rdy), 32'd0);
    chk("R10 stale completion tag", 32'(src0_tag), 32'd1);
    tick();
    fin(3'd1, 32'h55);
    cmp(3'd1);
    dsp(3'd3, 3'd3, 1'b0, 3'd0);
    chk("R9 newest value", src0_data, 32'h55);
    tick();
  endtask

  task automatic t_ignore();
    fin(3'd0, 32'h99);
    dsp(3'd0, 3'd0, 1'b1, 3'd6);
    chk("R5 r6 tag", 32'(disp_dst_tag), 32'd0);
    tick();
    dsp(3'd6, 3'd6, 1'b0, 3'd0);
    chk("R8 finish to free entry ignored", 32'(src0_rdy), 32'd0);
    tick();
    fin(3'd0, 32'h66);
    cmp(3'd0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) begin
      dsp(3'd0, 3'd0, 1'b1, 3'(i));
      chk("R5 fill tag", 32'(disp_dst_tag), 32'(i));
      tick();
    end
    dsp(3'd0, 3'd0, 1'b1, 3'd1);
    chk("R7 stall raised", 32'(disp_stall), 32'd1);
    chk("R7 ready dropped", 32'(disp_ready), 32'd0);
    tick();
    dsp(3'd1, 3'd1, 1'b0, 3'd0);
    chk("R7 no-dest dispatch ready", 32'(disp_ready), 32'd1);
    chk("R7 no-dest no stall", 32'(disp_stall), 32'd0);
    chk("R7 refused alloc left mapping", 32'(src0_tag), 32'd1);
    tick();
    fin(3'd3, 32'h77);
    cmp(3'd3);
    dsp(3'd0, 3'd0, 1'b1, 3'd2);
    chk("R7 freed entry reused", 32'(disp_dst_tag), 32'd3);
    tick();
    for (int i = 0; i < 8; i++) begin
      fin(3'(i), 32'h100 + 32'(i));
      cmp(3'(i));
    end
  endtask

  task automatic t_collide();
    dsp(3'd0, 3'd0, 1'b1, 3'd4);
    chk("R5 r4 tag", 32'(disp_dst_tag), 32'd0);
    tick();
    fin(3'd0, 32'hAB);
    cmp_valid = 1'b1; cmp_tag = 3'd0;
    dsp(3'd0, 3'd0, 1'b1, 3'd4);
    chk("R12 completing entry not reused", 32'(disp_dst_tag), 32'd1);
    tick();
    dsp(3'd4, 3'd4, 1'b0, 3'd0);
    chk("R12 new mapping kept rdy", 32'(src0_rdy), 32'd0);
    chk("R12 new mapping kept tag", 32'(src0_tag), 32'd1);
    tick();
    fin(3'd1, 32'hCD);
    cmp(3'd1);
    dsp(3'd4, 3'd4, 1'b0, 3'd0);
    chk("R9 r4 final", src0_data, 32'hCD);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_finish();
    t_forward();
    t_complete();
    t_nodst();
    t_stale();
    t_ignore();
    t_full();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule